// File: doc/BRIEF.md
# Bidirectional Interrupt Level Router

This block sits between two backplane segments, a local one and a remote one. It carries seven active-low, level-type interrupt request lines, levels 1 to 7, across that boundary. Each level is configured on its own. An enable bit decides whether the level crosses the boundary at all. A direction bit decides which segment is the source and which is the destination. When a handler on the destination side acknowledges an interrupt, the acknowledge request travels back the other way, so it reaches whichever side raised the interrupt.

The unit's own interrupt sources always appear on the local segment. They cross to the remote segment only through the same per-level routing. Software sets up the routing through a single 16-bit configuration word. That word can be written whole or one byte at a time, and it can be read back at any time.

There are two reset inputs, and they act differently. A hard reset clears the whole configuration. A soft reset preserves it and blocks any write that arrives while the soft reset is asserted.

Each level's path is set by a small route selector with three named states:
- ROUTE_OFF: the level is not enabled.
- ROUTE_L2R: the level is enabled and its direction bit is 0, so local drives remote.
- ROUTE_R2L: the level is enabled and its direction bit is 1, so remote drives local.

The selector moves between these states only when the configuration word changes. The possible moves are:
- enable: ROUTE_OFF to ROUTE_L2R or ROUTE_R2L.
- disable: either routed state back to ROUTE_OFF.
- reverse: between ROUTE_L2R and ROUTE_R2L.

Top module: `irq_level_router`

## Requirements
- R1: The read word `cfg_rdata` places the enable for level k at bit 7+k (bits 14..8 hold levels 7..1) and the direction for level k at bit k-1 (bits 6..0 hold levels 7..1). Bits 15 and 7 always read 0, and any value written to them is discarded.
- R2: A write happens when `cfg_sel` and `cfg_wr` are both high at a rising clock edge. Lane strobe `cfg_be[1]` loads the enables from bits 14..8, and lane strobe `cfg_be[0]` loads the directions from bits 6..0. The two lanes are independent. The new value reads back after that edge.
- R3: No write happens when `cfg_sel` or `cfg_wr` is low. In that case the configuration is unchanged.
- R4: A hard reset (`hard_rst_n` low) clears every enable and direction bit, so `cfg_rdata` reads 0.
- R5: A soft reset leaves all enable and direction bits unchanged. A write attempted while `soft_rst` is high is ignored.
- R6: For a disabled level, nothing crosses in either direction. `rmt_irq_drv_n`, `lcl_iack_drv_n` and `rmt_iack_drv_n` stay high, and `lcl_irq_drv_n` follows only `self_irq_n`.
- R7: For an enabled level with direction 0, `rmt_irq_drv_n` is low when `lcl_irq_n` or `self_irq_n` is low. `lcl_irq_drv_n` follows only `self_irq_n`, so the routed line never echoes back onto its source.
- R8: For an enabled level with direction 1, `lcl_irq_drv_n` is low when `rmt_irq_n` or `self_irq_n` is low, and `rmt_irq_drv_n` stays high.
- R9: Acknowledge requests go opposite to the interrupt. With direction 0, `lcl_iack_drv_n` follows `rmt_iack_n` and `rmt_iack_drv_n` stays high. With direction 1, `rmt_iack_drv_n` follows `lcl_iack_n` and `lcl_iack_drv_n` stays high.
- R10: Levels are independent. The routing of one level depends only on that level's own bits and lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Soft reset, active high; configuration is kept |
| cfg_sel | input | 1 | Register-select strobe |
| cfg_wr | input | 1 | Write request |
| cfg_be | input | 2 | Byte-lane strobes: [1] upper byte, [0] lower byte |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Configuration read-back |
| self_irq_n | input | 7 | Unit's own interrupt requests, bit k-1 for level k, active low |
| lcl_irq_n | input | 7 | Local-segment interrupt lines |
| rmt_irq_n | input | 7 | Remote-segment interrupt lines |
| lcl_irq_drv_n | output | 7 | Drive onto local-segment interrupt lines |
| rmt_irq_drv_n | output | 7 | Drive onto remote-segment interrupt lines |
| lcl_iack_n | input | 7 | Acknowledge requests seen on local segment |
| rmt_iack_n | input | 7 | Acknowledge requests seen on remote segment |
| lcl_iack_drv_n | output | 7 | Acknowledge requests forwarded onto local segment |
| rmt_iack_drv_n | output | 7 | Acknowledge requests forwarded onto remote segment |

## Verification
The routing paths are exercised under four input patterns, and each pattern separates different faults:
- All lines idle, which shows that nothing is driven by default.
- A single active level walked across all seven levels, which exposes swapped or shifted level indices.
- Every line active at once on both segments, which exposes echo paths and a wrong choice of source segment.
- Acknowledge-only activity, which catches acknowledges sent in the same direction as the interrupt.

Each pattern is applied with all levels disabled, with all levels routed local-to-remote, with all levels routed remote-to-local, and with a mixed checkerboard configuration that tells per-level bit decoding apart from global behaviour. Register writes use each lane strobe alone and the full word. They are tried with `cfg_sel` or `cfg_wr` missing and during a soft reset, which distinguishes blocked writes from lost ones.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
    localparam int NLEV    = 7;
    localparam int WORD_W  = 16;
    localparam int LANE_W  = WORD_W / 2;
    localparam int EN_LSB  = LANE_W;

    typedef enum logic [1:0] {
        ROUTE_OFF = 2'd0,
        ROUTE_L2R = 2'd1,
        ROUTE_R2L = 2'd2
    } route_t;
endpackage

// File: rtl/irqr_cfg_reg.sv
module irqr_cfg_reg
    import irqr_pkg::*;
#(
    parameter int N = NLEV
) (
    input  logic              clk,
    input  logic              hard_rst_n,
    input  logic              soft_rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [1:0]        be,
    input  logic [WORD_W-1:0] wdata,
    output logic [N-1:0]      en,
    output logic [N-1:0]      dir,
    output logic [WORD_W-1:0] rdata
);
    logic wr_ok;
    assign wr_ok = sel && wr && !soft_rst;

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            en  <= '0;
            dir <= '0;
        end else if (wr_ok) begin
            if (be[1]) en  <= wdata[EN_LSB +: N];
            if (be[0]) dir <= wdata[0 +: N];
        end
    end

    always_comb begin
        rdata = '0;
        rdata[EN_LSB +: N] = en;
        rdata[0 +: N]      = dir;
    end
endmodule

// File: rtl/irqr_lane.sv
module irqr_lane
    import irqr_pkg::*;
(
    input  logic en,
    input  logic dir,
    input  logic self_irq_n,
    input  logic lcl_irq_n,
    input  logic rmt_irq_n,
    input  logic lcl_iack_n,
    input  logic rmt_iack_n,
    output logic lcl_irq_drv_n,
    output logic rmt_irq_drv_n,
    output logic lcl_iack_drv_n,
    output logic rmt_iack_drv_n
);
    route_t route;

    always_comb begin
        if (!en)      route = ROUTE_OFF;
        else if (dir) route = ROUTE_R2L;
        else          route = ROUTE_L2R;
    end

    always_comb begin
        lcl_irq_drv_n  = self_irq_n;
        rmt_irq_drv_n  = 1'b1;
        lcl_iack_drv_n = 1'b1;
        rmt_iack_drv_n = 1'b1;
        unique case (route)
            ROUTE_OFF: ;
            ROUTE_L2R: begin
                rmt_irq_drv_n  = lcl_irq_n & self_irq_n;
                lcl_iack_drv_n = rmt_iack_n;
            end
            ROUTE_R2L: begin
                lcl_irq_drv_n  = rmt_irq_n & self_irq_n;
                rmt_iack_drv_n = lcl_iack_n;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
    import irqr_pkg::*;
(
    input  logic              clk,
    input  logic              hard_rst_n,
    input  logic              soft_rst,
    input  logic              cfg_sel,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_be,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic [NLEV-1:0]   self_irq_n,
    input  logic [NLEV-1:0]   lcl_irq_n,
    input  logic [NLEV-1:0]   rmt_irq_n,
    output logic [NLEV-1:0]   lcl_irq_drv_n,
    output logic [NLEV-1:0]   rmt_irq_drv_n,
    input  logic [NLEV-1:0]   lcl_iack_n,
    input  logic [NLEV-1:0]   rmt_iack_n,
    output logic [NLEV-1:0]   lcl_iack_drv_n,
    output logic [NLEV-1:0]   rmt_iack_drv_n
);
    logic [NLEV-1:0] en;
    logic [NLEV-1:0] dir;

    irqr_cfg_reg #(.N(NLEV)) u_cfg (
        .clk       (clk),
        .hard_rst_n(hard_rst_n),
        .soft_rst  (soft_rst),
        .sel       (cfg_sel),
        .wr        (cfg_wr),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .en        (en),
        .dir       (dir),
        .rdata     (cfg_rdata)
    );

    for (genvar g = 0; g < NLEV; g++) begin : g_lane
        irqr_lane u_lane (
            .en            (en[g]),
            .dir           (dir[g]),
            .self_irq_n    (self_irq_n[g]),
            .lcl_irq_n     (lcl_irq_n[g]),
            .rmt_irq_n     (rmt_irq_n[g]),
            .lcl_iack_n    (lcl_iack_n[g]),
            .rmt_iack_n    (rmt_iack_n[g]),
            .lcl_irq_drv_n (lcl_irq_drv_n[g]),
            .rmt_irq_drv_n (rmt_irq_drv_n[g]),
            .lcl_iack_drv_n(lcl_iack_drv_n[g]),
            .rmt_iack_drv_n(rmt_iack_drv_n[g])
        );
    end
endmodule

// File: rtl/irqr_chk.sv
module irqr_chk
    import irqr_pkg::*;
(
    input logic              clk,
    input logic              hard_rst_n,
    input logic              soft_rst,
    input logic              cfg_sel,
    input logic              cfg_wr,
    input logic [1:0]        cfg_be,
    input logic [WORD_W-1:0] cfg_wdata,
    input logic [WORD_W-1:0] cfg_rdata,
    input logic [NLEV-1:0]   self_irq_n,
    input logic [NLEV-1:0]   rmt_irq_n,
    input logic [NLEV-1:0]   lcl_iack_n,
    input logic [NLEV-1:0]   rmt_iack_n,
    input logic [NLEV-1:0]   lcl_irq_drv_n,
    input logic [NLEV-1:0]   rmt_irq_drv_n,
    input logic [NLEV-1:0]   lcl_iack_drv_n,
    input logic [NLEV-1:0]   rmt_iack_drv_n
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!hard_rst_n)
        cfg_rdata[WORD_W-1] == 1'b0 && cfg_rdata[LANE_W-1] == 1'b0);

    a_r3_no_write_hold: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !(cfg_sel && cfg_wr) |=> $stable(cfg_rdata));

    a_r5_soft_blocks_write: assert property (@(posedge clk) disable iff (!hard_rst_n)
        soft_rst |=> $stable(cfg_rdata));

    a_r2_low_lane_only: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (cfg_sel && cfg_wr && !soft_rst && cfg_be == 2'b01) |=>
        (cfg_rdata[WORD_W-1:LANE_W] == $past(cfg_rdata[WORD_W-1:LANE_W])) &&
        (cfg_rdata[NLEV-1:0] == $past(cfg_wdata[NLEV-1:0])));

    a_r2_high_lane_only: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (cfg_sel && cfg_wr && !soft_rst && cfg_be == 2'b10) |=>
        (cfg_rdata[LANE_W-1:0] == $past(cfg_rdata[LANE_W-1:0])) &&
        (cfg_rdata[EN_LSB +: NLEV] == $past(cfg_wdata[EN_LSB +: NLEV])));

    for (genvar g = 0; g < NLEV; g++) begin : g_lv
        // R6: a disabled level forwards nothing
        a_r6_off_quiet: assert property (@(posedge clk) disable iff (!hard_rst_n)
            !cfg_rdata[EN_LSB+g] |-> (rmt_irq_drv_n[g] && lcl_iack_drv_n[g] &&
                                      rmt_iack_drv_n[g] && lcl_irq_drv_n[g] == self_irq_n[g]));
        // R8: remote-to-local never drives the remote interrupt line
        a_r8_r2l_no_echo: assert property (@(posedge clk) disable iff (!hard_rst_n)
            (cfg_rdata[EN_LSB+g] && cfg_rdata[g]) |->
            (rmt_irq_drv_n[g] && lcl_irq_drv_n[g] == (rmt_irq_n[g] & self_irq_n[g])));
        // R9: acknowledge runs opposite to the interrupt
        a_r9_iack_opposite: assert property (@(posedge clk) disable iff (!hard_rst_n)
            cfg_rdata[EN_LSB+g] |->
            (cfg_rdata[g] ? (lcl_iack_drv_n[g] && rmt_iack_drv_n[g] == lcl_iack_n[g])
                          : (rmt_iack_drv_n[g] && lcl_iack_drv_n[g] == rmt_iack_n[g])));
    end
endmodule

bind irq_level_router irqr_chk u_chk (
    .clk           (clk),
    .hard_rst_n    (hard_rst_n),
    .soft_rst      (soft_rst),
    .cfg_sel       (cfg_sel),
    .cfg_wr        (cfg_wr),
    .cfg_be        (cfg_be),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .self_irq_n    (self_irq_n),
    .rmt_irq_n     (rmt_irq_n),
    .lcl_iack_n    (lcl_iack_n),
    .rmt_iack_n    (rmt_iack_n),
    .lcl_irq_drv_n (lcl_irq_drv_n),
    .rmt_irq_drv_n (rmt_irq_drv_n),
    .lcl_iack_drv_n(lcl_iack_drv_n),
    .rmt_iack_drv_n(rmt_iack_drv_n)
);

// File: tb/sim_irq_level_router.sv
`timescale 1ns/1ps
module sim_irq_level_router;
    logic        clk = 1'b0;
    logic        hard_rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [6:0]  self_irq_n = '1, lcl_irq_n = '1, rmt_irq_n = '1;
    logic [6:0]  lcl_iack_n = '1, rmt_iack_n = '1;
    logic [6:0]  lcl_irq_drv_n, rmt_irq_drv_n, lcl_iack_drv_n, rmt_iack_drv_n;

    always #5 clk = ~clk;

    irq_level_router u0 (
        .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst),
        .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .self_irq_n(self_irq_n), .lcl_irq_n(lcl_irq_n), .rmt_irq_n(rmt_irq_n),
        .lcl_irq_drv_n(lcl_irq_drv_n), .rmt_irq_drv_n(rmt_irq_drv_n),
        .lcl_iack_n(lcl_iack_n), .rmt_iack_n(rmt_iack_n),
        .lcl_iack_drv_n(lcl_iack_drv_n), .rmt_iack_drv_n(rmt_iack_drv_n)
    );

    typedef struct {
        string       req;
        logic [15:0] rd;
        logic [6:0]  li, ri, la, ra;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [6:0] m_en = '0, m_dir = '0;

    // expected values straight from R1 and R6..R9
    task automatic push_exp(input string req);
        exp_t e;
        e.req = req;
        e.rd  = {1'b0, m_en, 1'b0, m_dir};
        for (int k = 0; k < 7; k++) begin
            e.li[k] = self_irq_n[k]; e.ri[k] = 1'b1; e.la[k] = 1'b1; e.ra[k] = 1'b1;
            if (m_en[k] && !m_dir[k]) begin
                e.ri[k] = lcl_irq_n[k] & self_irq_n[k];
                e.la[k] = rmt_iack_n[k];
            end else if (m_en[k] && m_dir[k]) begin
                e.li[k] = rmt_irq_n[k] & self_irq_n[k];
                e.ra[k] = lcl_iack_n[k];
            end
        end
        q.push_back(e);
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            wait (q.size() > 0);
            #1;
            begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (cfg_rdata !== e.rd || lcl_irq_drv_n !== e.li || rmt_irq_drv_n !== e.ri ||
                    lcl_iack_drv_n !== e.la || rmt_iack_drv_n !== e.ra) begin
                    n_fail++;
                    $display("FAIL %s: got rd=%h li=%b ri=%b la=%b ra=%b exp rd=%h li=%b ri=%b la=%b ra=%b",
                             e.req, cfg_rdata, lcl_irq_drv_n, rmt_irq_drv_n, lcl_iack_drv_n,
                             rmt_iack_drv_n, e.rd, e.li, e.ri, e.la, e.ra);
                end
            end
        end
    end

    task automatic drive(input logic [6:0] s, l, r, la, ra, input string req);
        @(negedge clk);
        self_irq_n = s; lcl_irq_n = l; rmt_irq_n = r; lcl_iack_n = la; rmt_iack_n = ra;
        push_exp(req);
        #3;
    endtask

    // one-cycle write; model follows R2/R3/R5
    task automatic wr_cfg(input logic sel, input logic wr, input logic [1:0] be,
                          input logic [15:0] d, input logic srst);
        @(negedge clk);
        cfg_sel = sel; cfg_wr = wr; cfg_be = be; cfg_wdata = d; soft_rst = srst;
        @(negedge clk);
        if (sel && wr && !srst) begin
            if (be[1]) m_en  = d[14:8];
            if (be[0]) m_dir = d[6:0];
        end
        cfg_sel = 1'b0; cfg_wr = 1'b0; cfg_be = 2'b00; soft_rst = 1'b0;
    endtask

    task automatic patterns(input string req);
        drive('1, '1, '1, '1, '1, {req, " idle"});
        for (int k = 0; k < 7; k++) begin
            drive('1, ~(7'd1 << k), '1, '1, '1, {req, " walk lcl"});
            drive('1, '1, ~(7'd1 << k), '1, '1, {req, " walk rmt"});
        end
        drive('0, '1, '1, '1, '1, {req, " self all"});
        drive('1, '0, '0, '1, '1, {req, " both segs"});
        drive('1, '1, '1, '0, '1, {req, " iack lcl"});
        drive('1, '1, '1, '1, '0, {req, " iack rmt"});
        drive(7'b1010101, 7'b0110011, 7'b1100110, 7'b0001111, 7'b1110000, {req, " mixed"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        drive('1, '1, '1, '1, '1, "R4 reset state");
        hard_rst_n = 1'b1;
        patterns("R6 all disabled");
        wr_cfg(1, 1, 2'b11, 16'hFFFF, 0);            // R1: reserved bits 15 and 7 dropped
        drive('1, '1, '1, '1, '1, "R1 reserved bits read 0");
        wr_cfg(1, 1, 2'b01, 16'h0000, 0);
        drive('1, '1, '1, '1, '1, "R2 low lane only");
        patterns("R7 R9 local-to-remote");
        wr_cfg(1, 1, 2'b01, 16'h007F, 0);
        patterns("R8 R9 remote-to-local");
        wr_cfg(1, 1, 2'b11, 16'h5533, 0);
        patterns("R10 mixed levels");
        wr_cfg(1, 1, 2'b10, 16'h2A00, 0);
        drive('1, '0, '0, '0, '0, "R2 high lane only");
        wr_cfg(0, 1, 2'b11, 16'h0000, 0);
        drive('1, '1, '1, '1, '1, "R3 no sel");
        wr_cfg(1, 0, 2'b11, 16'h0000, 0);
        drive('1, '1, '1, '1, '1, "R3 no wr");
        wr_cfg(1, 1, 2'b11, 16'h0000, 1);
        drive('1, '0, '0, '0, '0, "R5 soft reset keeps config");
        wr_cfg(1, 1, 2'b11, 16'h7F7F, 0);
        @(negedge clk);
        hard_rst_n = 1'b0;
        m_en = '0; m_dir = '0;
        drive('1, '0, '0, '0, '0, "R4 hard reset clears");
        hard_rst_n = 1'b1;
        wait (q.size() == 0);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule